// File: doc/BRIEF.md
# Four-Way Write-Through Data Cache with Least-Frequently-Used Replacement

This block is a small data cache that sits between an 8-bit processor and a synchronous main memory. It has four sets of four ways. Each line holds a two-byte block, and the byte at the even address sits in the low word. Reads that hit return data in the same cycle as the request. A read miss fetches the whole block from memory, installs it and returns the requested byte. Every write goes through to memory. A write that hits also updates the cached byte. A write that misses first allocates and fills the line, and then performs the write.

Each line keeps a 4-bit saturating reference counter. On a miss the cache fills an empty way if the set has one. When the set is full, it evicts the line whose counter is lowest, and among equal counters the lowest-numbered way loses. The processor keeps its request, address, write flag and write data steady until the cache raises ready.

Top module: `lfu_wt_cache`

## Requirements
- R1: After reset every line is invalid: with no request, ready and the memory request are low, and the first access to any address reaches memory.
- R2: The address splits into tag = bits [7:3], set = bits [2:1] and word = bit 0. Word 0 of a block is the byte at the even address and word 1 is the byte at the odd address.
- R3: A read hit raises ready in the same cycle as the request, returns the cached byte and makes no memory access.
- R4: A read miss requests a memory read at the block base address (bit 0 cleared) and holds the request and address steady until the acknowledge. Memory then delivers word 0 in the next cycle and word 1 in the cycle after that. Ready and the requested byte appear in the second of those cycles, two cycles after the acknowledge.
- R5: Every write issues a memory write with the processor's address and byte, and ready rises in the acknowledge cycle. After a write hit, a read of that address hits and returns the written byte.
- R6: A write miss first fetches the whole block from the block base address, then writes the byte to both the line and memory. Afterwards both words of the block hit: one holds the written byte and the other holds the byte from memory.
- R7: While a set has an invalid way, a miss fills an invalid way, and no valid line is evicted.
- R8: In a full set, a miss evicts the line with the smallest reference count.
- R9: When the smallest count is shared by several lines, the lowest-numbered way among them is evicted. Ways are filled in ascending order.
- R10: A filled line starts with a count of 1. Each hit, read or write, adds one, and the count saturates at 15 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 8 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | Access completes in this cycle |
| cpu_rdata | output | 8 | Read byte, valid when ready on a read |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = memory write, 0 = block read |
| mem_addr | output | 8 | Memory address (block base for reads) |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory accepts the request in this cycle |
| mem_rdata | input | 8 | Read beat: word 0, then word 1, in the two cycles after the acknowledge |

## Verification
Two pairs of functions coincide in a single cycle. On a read miss to an odd address, the last fill beat is stored in the same cycle that it is forwarded to the processor. On a write miss, the merge of the written byte overlaps the store of the fill's final word. The bench provokes the first case with read misses at odd addresses and checks both the returned byte and its arrival exactly two cycles after the acknowledge. It provokes the second case with write misses, then reads both words back as hits to confirm that neither write overwrote the other.

// File: rtl/lfu_cache_pkg.sv
// Package: shared controller state encoding for the LFU write-through cache.
package lfu_cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a request; resolves hits
        ST_MRD,    // block read requested, waiting for acknowledge
        ST_FILL0,  // capturing word 0 of the block
        ST_FILL1,  // capturing word 1, installing line
        ST_MWR     // write-through to memory, waiting for acknowledge
    } cstate_t;
endpackage

// File: rtl/lfu_line_store.sv
// Module: lfu_line_store
// Holds valid bits, tags, reference counters and the two data words of every
// line. Reads are combinational for the addressed set. Writes act on the set
// addressed by idx and the way given by way.
// Assumes install and bump are never requested in the same cycle.
module lfu_line_store #(
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             idx,
    input  logic [WAY_W-1:0]             way,
    input  logic                         w0_en,
    input  logic [DATA_W-1:0]            w0_data,
    input  logic                         w1_en,
    input  logic [DATA_W-1:0]            w1_data,
    input  logic                         install_en,
    input  logic [TAG_W-1:0]             install_tag,
    input  logic                         bump_en,
    output logic [WAYS-1:0]              rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0][CNT_W-1:0]   rd_cnt,
    output logic [WAYS-1:0][DATA_W-1:0]  rd_w0,
    output logic [WAYS-1:0][DATA_W-1:0]  rd_w1
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic              valid_q [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [CNT_W-1:0]  cnt_q   [SETS][WAYS];
    logic [DATA_W-1:0] w0_q    [SETS][WAYS];
    logic [DATA_W-1:0] w1_q    [SETS][WAYS];

    // Purpose: present every way of the addressed set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_valid[w] = valid_q[idx][w];
            rd_tag[w]   = tag_q[idx][w];
            rd_cnt[w]   = cnt_q[idx][w];
            rd_w0[w]    = w0_q[idx][w];
            rd_w1[w]    = w1_q[idx][w];
        end
    end

    // Purpose: clear all lines on reset, otherwise apply fill, write and count updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    tag_q[s][w]   <= '0;
                    cnt_q[s][w]   <= '0;
                    w0_q[s][w]    <= '0;
                    w1_q[s][w]    <= '0;
                end
            end
        end else begin
            if (w0_en) w0_q[idx][way] <= w0_data;
            if (w1_en) w1_q[idx][way] <= w1_data;
            if (install_en) begin
                valid_q[idx][way] <= 1'b1;
                tag_q[idx][way]   <= install_tag;
                cnt_q[idx][way]   <= CNT_W'(1);
            end else if (bump_en && cnt_q[idx][way] != CNT_MAX) begin
                cnt_q[idx][way] <= cnt_q[idx][way] + CNT_W'(1);
            end
        end
    end

    // R10: only resident lines are counted as hits.
    p_bump_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bump_en |-> valid_q[idx][way]);

    // R10: a freshly installed line starts at a count of one.
    p_install_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        install_en |=> cnt_q[$past(idx)][$past(way)] == CNT_W'(1));

    // R10: a saturated counter does not wrap on another hit.
    p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bump_en && !install_en && cnt_q[idx][way] == CNT_MAX)
        |=> cnt_q[$past(idx)][$past(way)] == CNT_MAX);
endmodule

// File: rtl/lfu_tag_match.sv
// Module: lfu_tag_match
// Compares the request tag with every valid way of the addressed set and
// encodes the matching way. Assumes a tag is resident at most once per set.
module lfu_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 5,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           tag_in,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] hit_vec;

    // Purpose: one comparator per way.
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == tag_in);
    end

    // Purpose: encode the matching way.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |hit_vec;

    // R3: at most one way may match, or the returned byte would be ambiguous.
    p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/lfu_victim_pick.sv
// Module: lfu_victim_pick
// Picks the way to refill in the addressed set: the lowest invalid way if
// any, otherwise the way with the smallest reference count, with the lower
// way winning ties. Purely combinational; clk and rst_n serve the checks.
module lfu_victim_pick #(
    parameter int WAYS  = 4,
    parameter int CNT_W = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][CNT_W-1:0] cnt,
    output logic [WAY_W-1:0]           victim
);
    logic [WAY_W-1:0] free_way;
    logic             have_free;
    logic [WAY_W-1:0] min_way;
    logic [CNT_W-1:0] min_cnt;

    // Purpose: lowest-numbered invalid way.
    always_comb begin
        have_free = 1'b0;
        free_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                have_free = 1'b1;
                free_way  = WAY_W'(w);
            end
        end
    end

    // Purpose: smallest count, scanning upward with strict compare so ties keep the lower way.
    always_comb begin
        min_way = '0;
        min_cnt = cnt[0];
        for (int w = 1; w < WAYS; w++) begin
            if (cnt[w] < min_cnt) begin
                min_cnt = cnt[w];
                min_way = WAY_W'(w);
            end
        end
    end

    assign victim = have_free ? free_way : min_way;

    // R7: with an empty way present, the pick is an empty way.
    p_fill_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(&valid) |-> !valid[victim]);

    for (genvar g = 0; g < WAYS; g++) begin : g_chk
        // R8: in a full set no line has a smaller count than the pick.
        p_min_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (&valid) |-> (cnt[victim] <= cnt[g]));
        // R9: every lower way than the pick has a strictly larger count.
        p_tie_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ((&valid) && (WAY_W'(g) < victim)) |-> (cnt[g] > cnt[victim]));
    end
endmodule

// File: rtl/lfu_wt_cache.sv
// Module: lfu_wt_cache (top)
// Four-way, four-set write-through data cache with two-byte blocks and
// least-frequently-used replacement. Read hits finish in the request cycle;
// read misses fill a whole block; writes always go to memory, and write misses
// allocate first. Assumes the processor holds request, address, write flag
// and data steady until ready, and that memory returns the two block words in
// the two cycles after its acknowledge.
module lfu_wt_cache
    import lfu_cache_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_W = 1;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W = $clog2(WAYS);

    cstate_t state_q, state_d;
    logic [WAY_W-1:0] vic_q;

    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    logic             req_off;

    assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx = cpu_addr[OFF_W +: IDX_W];
    assign req_off = cpu_addr[0];

    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0][CNT_W-1:0]  rd_cnt;
    logic [WAYS-1:0][DATA_W-1:0] rd_w0;
    logic [WAYS-1:0][DATA_W-1:0] rd_w1;

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim;

    logic              w0_en, w1_en, install_en, bump_en;
    logic [DATA_W-1:0] w0_data, w1_data;
    logic [WAY_W-1:0]  wr_way;

    lfu_line_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .idx(req_idx), .way(wr_way),
        .w0_en(w0_en), .w0_data(w0_data), .w1_en(w1_en), .w1_data(w1_data),
        .install_en(install_en), .install_tag(req_tag), .bump_en(bump_en),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_cnt(rd_cnt),
        .rd_w0(rd_w0), .rd_w1(rd_w1)
    );

    lfu_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .clk(clk), .rst_n(rst_n), .valid(rd_valid), .tags(rd_tag),
        .tag_in(req_tag), .hit(hit), .hit_way(hit_way)
    );

    lfu_victim_pick #(.WAYS(WAYS), .CNT_W(CNT_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .valid(rd_valid), .cnt(rd_cnt), .victim(victim)
    );

    // Purpose: hits address the matching way, all fill work addresses the latched victim.
    assign wr_way = (state_q == ST_IDLE) ? hit_way : vic_q;

    // Purpose: next state, store controls, processor and memory outputs.
    always_comb begin
        state_d    = state_q;
        cpu_ready  = 1'b0;
        cpu_rdata  = '0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        w0_en      = 1'b0;
        w1_en      = 1'b0;
        w0_data    = cpu_wdata;
        w1_data    = cpu_wdata;
        install_en = 1'b0;
        bump_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        bump_en = 1'b1;
                        if (cpu_we) begin
                            w0_en   = !req_off;
                            w1_en   = req_off;
                            state_d = ST_MWR;
                        end else begin
                            cpu_ready = 1'b1;
                            cpu_rdata = req_off ? rd_w1[hit_way] : rd_w0[hit_way];
                        end
                    end else begin
                        state_d = ST_MRD;
                    end
                end
            end
            ST_MRD: begin
                mem_req  = 1'b1;
                mem_addr = {req_tag, req_idx, 1'b0};
                if (mem_ack) state_d = ST_FILL0;
            end
            ST_FILL0: begin
                w0_en   = 1'b1;
                w0_data = mem_rdata;
                state_d = ST_FILL1;
            end
            ST_FILL1: begin
                install_en = 1'b1;
                w1_en      = 1'b1;
                w1_data    = mem_rdata;
                if (cpu_we) begin
                    if (req_off) begin
                        w1_data = cpu_wdata;
                    end else begin
                        w0_en   = 1'b1;
                        w0_data = cpu_wdata;
                    end
                    state_d = ST_MWR;
                end else begin
                    cpu_ready = 1'b1;
                    cpu_rdata = req_off ? mem_rdata : rd_w0[vic_q];
                    state_d   = ST_IDLE;
                end
            end
            ST_MWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cpu_addr;
                mem_wdata = cpu_wdata;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register and victim latch taken when a miss is detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vic_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req && !hit) vic_q <= victim;
        end
    end

    // R3: a read hit completes at once without touching memory.
    p_read_hit_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && !cpu_we && hit) |-> (cpu_ready && !mem_req));

    // R4: a memory request and its address stay put until acknowledged.
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: a write only completes while memory accepts the write.
    p_write_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we) |-> (mem_req && mem_we && mem_ack));

    // R6: a write miss reads the block before it writes memory.
    p_alloc_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && cpu_we && !hit) |=> (mem_req && !mem_we));

    // R1: nothing is signalled to memory or the processor without a request.
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !cpu_req) |-> (!cpu_ready && !mem_req));
endmodule

// File: tb/sim_lfu_wt_cache.sv
module sim_lfu_wt_cache;
    localparam int PERIOD  = 10;
    localparam int MEM_LAT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_ready;
    logic [7:0] cpu_rdata;
    logic       mem_req, mem_we, mem_ack;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = '0;

    int nchk = 0;
    int nerr = 0;

    always #(PERIOD/2) clk = ~clk;

    lfu_wt_cache u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // Memory model: acknowledge after MEM_LAT waiting cycles, then two read beats.
    logic [7:0] mem [256];
    int   wcnt = 0;
    int   cyc = 0;
    int   rd_count = 0;
    int   wr_count = 0;
    int   ack_cyc = 0;
    logic [7:0] rd_last_addr = '0;
    logic [7:0] wr_last_addr = '0;
    logic [7:0] wr_last_data = '0;
    logic [7:0] base = '0;
    logic       phase = 1'b0;

    function automatic logic [7:0] init_val(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = init_val(a);
    end

    assign mem_ack = mem_req && (wcnt == MEM_LAT);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && !mem_ack) wcnt <= wcnt + 1;
        else wcnt <= 0;
        phase <= 1'b0;
        if (mem_req && mem_ack && !mem_we) begin
            base         <= mem_addr;
            phase        <= 1'b1;
            mem_rdata    <= mem[mem_addr];
            rd_count     <= rd_count + 1;
            rd_last_addr <= mem_addr;
            ack_cyc      <= cyc;
        end else if (phase) begin
            mem_rdata <= mem[base | 8'h01];
        end
        if (mem_req && mem_ack && mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_count      <= wr_count + 1;
            wr_last_addr  <= mem_addr;
            wr_last_data  <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One processor access; returns data, wait cycles, fill flag, write flag, fill latency.
    task automatic access(input bit we, input logic [7:0] addr, input logic [7:0] wd,
                          output logic [7:0] rd, output int waits, output bit filled,
                          output bit wrote, output int lat);
        int r0, w0, rcyc;
        @(negedge clk);
        r0 = rd_count;
        w0 = wr_count;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        waits = 0;
        forever begin
            #1;
            if (cpu_ready) break;
            @(negedge clk);
            waits++;
            if (waits > 60) break;
        end
        rd = cpu_rdata;
        rcyc = cyc;
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        filled = (rd_count != r0);
        wrote  = (wr_count != w0);
        lat    = rcyc - ack_cyc;
        if (waits > 60) chk(1'b0, "watchdog access", waits, 60);
    endtask

    task automatic rd_hit(input logic [7:0] addr, input logic [7:0] exp, input string req);
        logic [7:0] d; int w, l; bit f, wr;
        access(1'b0, addr, 8'h00, d, w, f, wr, l);
        chk(!f && w == 0, {req, " hit without memory"}, int'(f), 0);
        chk(d == exp, {req, " hit data"}, d, exp);
    endtask

    task automatic rd_miss(input logic [7:0] addr, input string req);
        logic [7:0] d; int w, l; bit f, wr;
        access(1'b0, addr, 8'h00, d, w, f, wr, l);
        chk(f, {req, " miss reaches memory"}, int'(f), 1);
        chk(d == mem[addr], {req, " miss data"}, d, mem[addr]);
    endtask

    task automatic t_reset;
        #1;
        chk(cpu_ready == 1'b0, "R1 ready low after reset", cpu_ready, 0);
        chk(mem_req == 1'b0, "R1 memory idle after reset", mem_req, 0);
    endtask

    // R4 and R2: odd-address miss, forwarding of the last beat, base address and timing.
    task automatic t_read_miss;
        logic [7:0] d; int w, l; bit f, wr;
        access(1'b0, 8'h01, 8'h00, d, w, f, wr, l);
        chk(f, "R1 first access misses", int'(f), 1);
        chk(rd_last_addr == 8'h00, "R4 fill at block base", rd_last_addr, 8'h00);
        chk(d == init_val(1), "R2 odd byte is word 1", d, init_val(1));
        chk(l == 2, "R4 ready two cycles after ack", l, 2);
        access(1'b0, 8'h08, 8'h00, d, w, f, wr, l);
        chk(f && d == init_val(8), "R2 even byte is word 0", d, init_val(8));
        chk(l == 2, "R4 latency even word", l, 2);
        rd_hit(8'h00, init_val(0), "R3 other word of filled block");
    endtask

    // R7 then R8 on set 0 (addresses with bits [2:1] = 00).
    task automatic t_lfu;
        rd_miss(8'h10, "R7 third way");
        rd_miss(8'h18, "R7 fourth way");
        // counts now: 0x00 ->2, 0x08 ->1, 0x10 ->1, 0x18 ->1
        rd_hit(8'h09, init_val(9), "R7 second way kept");
        rd_hit(8'h10, init_val(16), "R7 third way kept");
        rd_hit(8'h18, init_val(24), "R7 fourth way kept");
        rd_hit(8'h01, init_val(1), "R3 first way kept");
        rd_hit(8'h08, init_val(8), "R3 bump second");
        rd_hit(8'h08, init_val(8), "R3 bump second again");
        rd_hit(8'h11, init_val(17), "R3 bump third");
        // counts: 0x00 ->3, 0x08 ->4, 0x10 ->3, 0x18 ->2
        rd_miss(8'h20, "R8 new tag in full set");
        rd_hit(8'h00, init_val(0), "R8 count 3 line kept");
        rd_hit(8'h08, init_val(8), "R8 count 4 line kept");
        rd_hit(8'h10, init_val(16), "R8 count 3 line kept");
        rd_miss(8'h18, "R8 smallest count line was evicted");
    endtask

    // R9 on set 1: four equal counts, lowest way goes first.
    task automatic t_tie;
        rd_miss(8'h02, "R9 fill way0");
        rd_miss(8'h0A, "R9 fill way1");
        rd_miss(8'h12, "R9 fill way2");
        rd_miss(8'h1A, "R9 fill way3");
        rd_miss(8'h22, "R9 tie miss");
        rd_hit(8'h0A, init_val(10), "R9 way1 kept");
        rd_hit(8'h12, init_val(18), "R9 way2 kept");
        rd_hit(8'h1A, init_val(26), "R9 way3 kept");
        rd_miss(8'h02, "R9 lowest way was evicted");
    endtask

    // R10 on set 2: sixteen references must saturate at 15, not wrap to 0.
    task automatic t_saturate;
        rd_miss(8'h04, "R10 fill counted line");
        for (int i = 0; i < 15; i++) rd_hit(8'h04, init_val(4), "R10 repeated hit");
        rd_miss(8'h0C, "R10 fill second");
        rd_miss(8'h14, "R10 fill third");
        rd_miss(8'h1C, "R10 fill fourth");
        rd_miss(8'h24, "R10 miss in full set");
        rd_hit(8'h05, init_val(5), "R10 saturated line survives");
        rd_miss(8'h0C, "R10 count-1 line evicted");
    endtask

    // R5: write hit goes to memory and updates the line.
    task automatic t_write_hit;
        logic [7:0] d; int w, l; bit f, wr;
        access(1'b1, 8'h01, 8'hC3, d, w, f, wr, l);
        chk(wr && !f, "R5 write hit goes only to memory write", int'(f), 0);
        chk(wr_last_addr == 8'h01 && wr_last_data == 8'hC3, "R5 write address and data",
            {wr_last_addr, wr_last_data}, 16'h01C3);
        chk(mem[8'h01] == 8'hC3, "R5 memory updated", mem[8'h01], 8'hC3);
        rd_hit(8'h01, 8'hC3, "R5 cache updated");
        rd_hit(8'h00, init_val(0), "R5 neighbour word unchanged");
    endtask

    // R6: write miss allocates, then writes; both words readable as hits.
    task automatic t_write_miss;
        logic [7:0] d; int w, l; bit f, wr;
        access(1'b1, 8'h07, 8'h9E, d, w, f, wr, l);
        chk(f && wr, "R6 fill and write both seen", {int'(f), int'(wr)}, 2'b11);
        chk(rd_last_addr == 8'h06, "R6 fill at block base", rd_last_addr, 8'h06);
        chk(mem[8'h07] == 8'h9E, "R6 memory written", mem[8'h07], 8'h9E);
        rd_hit(8'h07, 8'h9E, "R6 written word");
        rd_hit(8'h06, init_val(6), "R6 fetched word");
        access(1'b1, 8'h0E, 8'h3C, d, w, f, wr, l);
        rd_hit(8'h0E, 8'h3C, "R6 even word written");
        rd_hit(8'h0F, init_val(15), "R6 odd word fetched");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_miss();
        t_lfu();
        t_tie();
        t_saturate();
        t_write_hit();
        t_write_miss();
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule